// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Adder

This block is the arithmetic execute unit of one vector lane. It adds two single-precision floating-point operands. A lane controller streams one element pair per clock through a valid/data input. After a fixed fill delay, one sum per clock comes out with its own valid flag. The block has no stall and no back-pressure, so every accepted pair leaves exactly four clocks later.

The work is spread over four registered stages:

1. Stage one orders the two operands by magnitude and takes the exponent difference.
2. Stage two shifts the smaller significand right until both operands share the larger exponent. Bits shifted out are folded into a sticky bit.
3. Stage three adds or subtracts the aligned significands. The result is always a non-negative magnitude, because the larger operand is known from stage one.
4. Stage four normalises the result. It shifts right one place on carry-out, or shifts left by the leading-zero count after cancellation, and adjusts the exponent to match. The result is truncated toward zero.

Operands are taken as normal numbers. An operand whose exponent field is zero is treated as the value zero. Results that would leave the normal exponent range, and special values, are outside the block's contract.

Top module: `fp_add_pipe`

## Requirements
- R1: A sum leaves on `out_valid` exactly four rising edges after its operand pair is accepted with `in_valid` high. The accepting edge counts as the first. `out_valid` is never high in any other cycle.
- R2: A new pair may be accepted on every edge, and results leave in input order. A back-to-back stream of N pairs has its last result valid after N+3 edges following the first accepting edge, so six pairs complete in nine edges.
- R3: When both operands have the same sign, the sum has that sign and the magnitudes add. A carry out of the significand raises the exponent by one (for example 1.5 + 1.5 = 3.0, 0x40400000).
- R4: When the signs differ, the result carries the sign of the operand with the larger magnitude. The result does not depend on which port holds which operand (1.0 + -1.5 and -1.5 + 1.0 both give 0xBF000000).
- R5: After cancellation, the result is shifted left by its leading-zero count and the exponent is lowered to match. For example, 1.0 - (1 - 2^-24) gives 2^-24, 0x33800000.
- R6: A zero result is emitted as all 32 bits zero, so exponent, significand and sign are all zero.
- R7: Rounding truncates toward zero, with bits shifted out during alignment taking part in a subtraction:
  - 1.0 + 2^-24 gives 0x3F800000.
  - 1.0 - 2^-30 gives 0x3F7FFFFF.
  - 1.0 + 2^-30 gives 0x3F800000.
- R8: An operand with exponent field 0 is the value zero whatever its fraction bits hold. For example, 0x00000123 + 1.5 gives 0x3FC00000.
- R9: A synchronous active-high reset clears all stages. `out_valid` is low after reset, and pairs in flight when reset is applied never appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | EXP_W+MAN_W+1 | First operand: sign, exponent, fraction |
| in_b | input | EXP_W+MAN_W+1 | Second operand: sign, exponent, fraction |
| out_valid | output | 1 | Sum present this cycle |
| out_sum | output | EXP_W+MAN_W+1 | Sum, truncated toward zero |

## Verification
The bench builds the adder with its default widths, an 8-bit exponent and a 23-bit fraction. At these widths every expected value is an exact single-precision encoding that can be worked out by hand. This puts within reach the alignment shifts at both ends: a distance of zero, a distance of 24 that still leaves a guard bit, and a distance of 30 that exceeds the extended significand and survives only as sticky. It also covers a full 24-place left normalisation after cancellation. Streaming the table back to back exercises the nine-edge completion of six elements and the in-order drain, and a reset placed mid-stream checks that in-flight elements are flushed.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    // Number of zero bits above the highest set bit of v[w-1:0].
    function automatic int unsigned lead_zeros(input logic [63:0] v, input int w);
        int unsigned n;
        bit          seen;
        n    = 0;
        seen = 1'b0;
        for (int i = 63; i >= 0; i--) begin
            if (i < w && !seen) begin
                if (v[i]) seen = 1'b1;
                else      n++;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/fpadd_cmp.sv
module fpadd_cmp #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [EXP_W+MAN_W:0]   in_a,
    input  logic [EXP_W+MAN_W:0]   in_b,
    output logic                   c_vld,
    output logic                   c_sign,
    output logic [EXP_W-1:0]       c_exp,
    output logic [MAN_W:0]         c_big,
    output logic [MAN_W:0]         c_sml,
    output logic [EXP_W-1:0]       c_diff,
    output logic                   c_sub
);
    localparam int MAG_W = EXP_W + MAN_W;

    typedef struct packed {
        logic             vld;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W:0]   big;
        logic [MAN_W:0]   sml;
        logic [EXP_W-1:0] diff;
        logic             sub;
    } cmp_t;

    cmp_t st_d, st_q;

    logic [MAG_W-1:0]     mag_a, mag_b;
    logic [EXP_W+MAN_W:0] hi, lo;
    logic [EXP_W-1:0]     hi_e, lo_e;

    always_comb begin
        mag_a = in_a[MAG_W-1:0];
        mag_b = in_b[MAG_W-1:0];
        // exponent then fraction: one unsigned compare orders magnitudes
        if (mag_a >= mag_b) begin
            hi = in_a;
            lo = in_b;
        end else begin
            hi = in_b;
            lo = in_a;
        end
        hi_e = hi[MAG_W-1:MAN_W];
        lo_e = lo[MAG_W-1:MAN_W];

        st_d.vld  = in_valid;
        st_d.sign = hi[MAG_W];
        st_d.exp  = hi_e;
        // exponent field zero means value zero: drop fraction, no hidden bit
        st_d.big  = (hi_e != '0) ? {1'b1, hi[MAN_W-1:0]} : '0;
        st_d.sml  = (lo_e != '0) ? {1'b1, lo[MAN_W-1:0]} : '0;
        st_d.diff = hi_e - lo_e;
        st_d.sub  = in_a[MAG_W] ^ in_b[MAG_W];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign c_vld  = st_q.vld;
    assign c_sign = st_q.sign;
    assign c_exp  = st_q.exp;
    assign c_big  = st_q.big;
    assign c_sml  = st_q.sml;
    assign c_diff = st_q.diff;
    assign c_sub  = st_q.sub;
endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int XW    = MAN_W + 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             c_vld,
    input  logic             c_sign,
    input  logic [EXP_W-1:0] c_exp,
    input  logic [MAN_W:0]   c_big,
    input  logic [MAN_W:0]   c_sml,
    input  logic [EXP_W-1:0] c_diff,
    input  logic             c_sub,
    output logic             a_vld,
    output logic             a_sign,
    output logic [EXP_W-1:0] a_exp,
    output logic [XW-1:0]    a_big,
    output logic [XW-1:0]    a_sml,
    output logic             a_sub
);
    typedef struct packed {
        logic             vld;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [XW-1:0]    big;
        logic [XW-1:0]    sml;
        logic             sub;
    } aln_t;

    aln_t st_d, st_q;

    logic [XW-1:0] full, shifted;
    logic          lost;

    always_comb begin
        full = {c_sml, 3'b000};
        lost = 1'b0;
        if (int'(c_diff) >= XW) begin
            shifted = '0;
            lost    = |full;
        end else begin
            shifted = full >> c_diff;
            for (int i = 0; i < XW; i++) begin
                if (i < int'(c_diff)) lost = lost | full[i];
            end
        end

        st_d.vld  = c_vld;
        st_d.sign = c_sign;
        st_d.exp  = c_exp;
        st_d.big  = {c_big, 3'b000};
        st_d.sml  = {shifted[XW-1:1], shifted[0] | lost};
        st_d.sub  = c_sub;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign a_vld  = st_q.vld;
    assign a_sign = st_q.sign;
    assign a_exp  = st_q.exp;
    assign a_big  = st_q.big;
    assign a_sml  = st_q.sml;
    assign a_sub  = st_q.sub;
endmodule

// File: rtl/fpadd_sum.sv
module fpadd_sum #(
    parameter int EXP_W = 8,
    parameter int XW    = 27
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_vld,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [XW-1:0]    a_big,
    input  logic [XW-1:0]    a_sml,
    input  logic             a_sub,
    output logic             s_vld,
    output logic             s_sign,
    output logic [EXP_W-1:0] s_exp,
    output logic [XW:0]      s_mag
);
    typedef struct packed {
        logic             vld;
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [XW:0]      mag;
    } sum_t;

    sum_t st_d, st_q;

    always_comb begin
        st_d.vld  = a_vld;
        st_d.sign = a_sign;
        st_d.exp  = a_exp;
        // a_big is never below a_sml, so the difference stays non-negative
        if (a_sub) st_d.mag = {1'b0, a_big} - {1'b0, a_sml};
        else       st_d.mag = {1'b0, a_big} + {1'b0, a_sml};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign s_vld  = st_q.vld;
    assign s_sign = st_q.sign;
    assign s_exp  = st_q.exp;
    assign s_mag  = st_q.mag;
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm
    import fpadd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    parameter int XW    = MAN_W + 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 s_vld,
    input  logic                 s_sign,
    input  logic [EXP_W-1:0]     s_exp,
    input  logic [XW:0]          s_mag,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] out_sum
);
    typedef struct packed {
        logic                 vld;
        logic [EXP_W+MAN_W:0] sum;
    } nrm_t;

    nrm_t st_d, st_q;

    int unsigned      lz;
    logic [XW-1:0]    norm;
    logic [EXP_W-1:0] e_out;
    logic [MAN_W-1:0] m_out;

    always_comb begin
        lz    = lead_zeros(64'(s_mag[XW-1:0]), XW);
        norm  = s_mag[XW-1:0] << lz;
        e_out = s_exp;
        m_out = '0;
        st_d.vld = s_vld;
        if (s_mag == '0) begin
            st_d.sum = '0;
        end else begin
            if (s_mag[XW]) begin
                e_out = s_exp + 1'b1;
                m_out = s_mag[XW-1 -: MAN_W];
            end else begin
                e_out = s_exp - EXP_W'(lz);
                m_out = norm[XW-2 -: MAN_W];
            end
            st_d.sum = {s_sign, e_out, m_out};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sum   = st_q.sum;
endmodule

// File: rtl/fp_add_pipe.sv
module fp_add_pipe #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] in_a,
    input  logic [EXP_W+MAN_W:0] in_b,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] out_sum
);
    localparam int XW = MAN_W + 4;

    logic             c_vld, c_sign, c_sub;
    logic [EXP_W-1:0] c_exp, c_diff;
    logic [MAN_W:0]   c_big, c_sml;

    logic             a_vld, a_sign, a_sub;
    logic [EXP_W-1:0] a_exp;
    logic [XW-1:0]    a_big, a_sml;

    logic             s_vld, s_sign;
    logic [EXP_W-1:0] s_exp;
    logic [XW:0]      s_mag;

    fpadd_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .c_vld(c_vld), .c_sign(c_sign), .c_exp(c_exp), .c_big(c_big),
        .c_sml(c_sml), .c_diff(c_diff), .c_sub(c_sub)
    );

    fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XW(XW)) u_align (
        .clk(clk), .rst(rst),
        .c_vld(c_vld), .c_sign(c_sign), .c_exp(c_exp), .c_big(c_big),
        .c_sml(c_sml), .c_diff(c_diff), .c_sub(c_sub),
        .a_vld(a_vld), .a_sign(a_sign), .a_exp(a_exp), .a_big(a_big),
        .a_sml(a_sml), .a_sub(a_sub)
    );

    fpadd_sum #(.EXP_W(EXP_W), .XW(XW)) u_sum (
        .clk(clk), .rst(rst),
        .a_vld(a_vld), .a_sign(a_sign), .a_exp(a_exp), .a_big(a_big),
        .a_sml(a_sml), .a_sub(a_sub),
        .s_vld(s_vld), .s_sign(s_sign), .s_exp(s_exp), .s_mag(s_mag)
    );

    fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .XW(XW)) u_norm (
        .clk(clk), .rst(rst),
        .s_vld(s_vld), .s_sign(s_sign), .s_exp(s_exp), .s_mag(s_mag),
        .out_valid(out_valid), .out_sum(out_sum)
    );
endmodule

// File: rtl/fp_add_pipe_chk.sv
module fp_add_pipe_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [EXP_W+MAN_W:0] in_a,
    input logic [EXP_W+MAN_W:0] in_b,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] out_sum
);
    localparam int SB = EXP_W + MAN_W;

    logic [3:0] vld_hist;
    logic [3:0] pos_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_hist <= '0;
            pos_hist <= '0;
        end else begin
            vld_hist <= {vld_hist[2:0], in_valid};
            pos_hist <= {pos_hist[2:0], in_valid & ~in_a[SB] & ~in_b[SB]};
        end
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vld_hist[3]);

    // R3
    same_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pos_hist[3]) |-> !out_sum[SB]);

    // R6
    zero_form_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sum[SB-1:MAN_W] == '0) |-> out_sum == '0);

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !out_valid);
endmodule

bind fp_add_pipe fp_add_pipe_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_sum(out_sum)
);

// File: tb/fp_add_pipe_test.sv
`timescale 1ns/1ps
module fp_add_pipe_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [31:0] out_sum;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fp_add_pipe uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_sum(out_sum)
    );

    // {a, b, expected sum}
    localparam int NV = 16;
    localparam logic [95:0] VEC [NV] = '{
        {32'h3F800000, 32'h40000000, 32'h40400000}, // R3 1+2
        {32'h3FC00000, 32'h3FC00000, 32'h40400000}, // R3 carry out
        {32'h40400000, 32'hBF800000, 32'h40000000}, // R4 3-1
        {32'h3F800000, 32'hBF800000, 32'h00000000}, // R6 1-1
        {32'h40200000, 32'hC0200000, 32'h00000000}, // R6 2.5-2.5
        {32'h3F800000, 32'hBFC00000, 32'hBF000000}, // R4 1-1.5
        {32'hBFC00000, 32'h3F800000, 32'hBF000000}, // R4 swapped ports
        {32'h3F800000, 32'h3F400000, 32'h3FE00000}, // R3 1+0.75
        {32'h42C80000, 32'h3E800000, 32'h42C88000}, // R3 100+0.25
        {32'h3F800000, 32'h33800000, 32'h3F800000}, // R7 1+2^-24
        {32'h3F800000, 32'hBF7FFFFF, 32'h33800000}, // R5 deep cancel
        {32'h3F800000, 32'hB0800000, 32'h3F7FFFFF}, // R7 sticky subtract
        {32'h30800000, 32'h3F800000, 32'h3F800000}, // R7 far shift
        {32'hBF800000, 32'hC0000000, 32'hC0400000}, // R3 negatives
        {32'h00000123, 32'h3FC00000, 32'h3FC00000}, // R8 zero exponent
        {32'h00400000, 32'h80000001, 32'h00000000}  // R8 both zero-exp
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 reset state", {31'b0, out_valid}, 32'h0);
        rst = 1'b0;

        // back-to-back stream: input t driven before edge t, its result
        // is sampled at the negedge before edge t+4
        for (int t = 0; t <= NV + 4; t++) begin
            @(negedge clk);
            if (t >= 4 && t - 4 < NV) begin
                check(out_valid == 1'b1, "R1 R2 valid in stream",
                      {31'b0, out_valid}, 32'h1);
                check(out_sum == VEC[t-4][31:0], $sformatf("R3-R8 vector %0d", t - 4),
                      out_sum, VEC[t-4][31:0]);
                if (t - 4 == 5)
                    check(out_valid == 1'b1, "R2 sixth element after nine edges",
                          {31'b0, out_valid}, 32'h1);
            end else begin
                check(out_valid == 1'b0, "R1 no early or extra valid",
                      {31'b0, out_valid}, 32'h0);
            end
            if (t < NV) begin
                in_valid = 1'b1;
                in_a     = VEC[t][95:64];
                in_b     = VEC[t][63:32];
            end else begin
                in_valid = 1'b0;
            end
        end

        // single element with bubbles: valid exactly on the fourth edge
        @(negedge clk);
        in_valid = 1'b1; in_a = 32'h40800000; in_b = 32'h40C00000;
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            if (k < 4) begin
                check(out_valid == 1'b0, "R1 latency not early", {31'b0, out_valid}, 32'h0);
                @(negedge clk);
            end else begin
                check(out_valid == 1'b1 && out_sum == 32'h41200000, "R1 R3 4+6 at latency 4",
                      out_sum, 32'h41200000);
            end
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R1 single pulse", {31'b0, out_valid}, 32'h0);

        // reset while elements are in flight
        in_valid = 1'b1; in_a = 32'h3F800000; in_b = 32'h3F800000;
        @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check(out_valid == 1'b0, "R9 in-flight flushed", {31'b0, out_valid}, 32'h0);
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule